// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block drives the word address and handshake side of a synchronous burst read from a 16-bit-word memory map. A one-cycle start request carries a start address, a burst mode and an initial latency. The sequencer waits out the latency and then issues one word address per clock. A ready flag marks the first word, and a valid flag stays high for every word issued.

In continuous mode the address climbs by one each clock. At the top of the memory region that holds the start address it folds back to that region's bottom, and this goes on until a stop condition arrives. In the fixed modes the burst is 4, 8, 16 or 32 words long. The address steps within a window aligned to the burst length, and the sequencer goes idle after the last word. Start addresses in reserved regions, undefined mode codes, and 32-word bursts on the buffer spare areas are refused with a one-cycle error flag.

Top module: `burst_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `valid_o`, `ready_o` and `err_o` are low.
- R2: After an accepted start sampled at clock edge E0, the first word appears after edge E_L, where L is `latency_i` and a value of 0 acts as 1. At that point `valid_o` and `ready_o` are high and `addr_o` equals the start address. `ready_o` is high for that one cycle only.
- R3: The region map in word addresses has ten regions:
  - plain regions: 0000h–01FFh, 0200h–05FFh, 0600h–09FFh, 8000h–800Fh and F000h–FFFFh;
  - buffer spare regions: 8010h–802Fh and 8030h–804Fh;
  - reserved regions: 0A00h–7FFFh, 8050h–8FFFh and 9000h–EFFFh.
- R4: Continuous mode uses `mode_i` = 0. It issues one word per clock with the address plus one. After the region's top address it issues the region's base address, and it continues until a stop condition.
- R5: `mode_i` codes 1, 2, 3 and 4 give fixed bursts of 4, 8, 16 and 32 words. The low log2(N) address bits count up modulo N while the upper bits stay fixed. After N words `valid_o` falls and the block is idle.
- R6: Any of the following, sampled at an edge during the latency wait or the burst, ends the operation: `ce_n_i` high, `rp_n_i` low, `rst_req_i` high, or `we_n_i` low. After that edge `valid_o` is low, and `ready_o` is never raised for a burst stopped during its wait.
- R7: A start whose address lies in a reserved region raises `err_o` for exactly the cycle after the start edge, and neither `valid_o` nor `ready_o` rises.
- R8: A start with `mode_i` = 4 in a buffer spare region, or with `mode_i` of 5, 6 or 7, is refused in the same way as R7. A 32-word burst in the 8000h–800Fh region is accepted.
- R9: A start request is ignored while a burst is in progress or while a stop condition is present. It causes no error and leaves the running sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start request |
| start_addr_i | input | 16 | Word address of the first word |
| mode_i | input | 3 | 0 continuous; 1/2/3/4 fixed 4/8/16/32 words |
| latency_i | input | LAT_W | Initial access latency in clocks |
| ce_n_i | input | 1 | Chip enable, active low; high ends a burst |
| rp_n_i | input | 1 | Reset pin, active low; low ends a burst |
| rst_req_i | input | 1 | Device reset request; high ends a burst |
| we_n_i | input | 1 | Write enable, active low; low ends a burst |
| addr_o | output | 16 | Word address being issued |
| valid_o | output | 1 | High while a word address is issued |
| ready_o | output | 1 | One-cycle marker of the first word |
| err_o | output | 1 | One-cycle flag for a refused start |

## Verification
The bench starts continuous bursts a few words below the tops of unevenly sized regions (0200h–05FFh, boot spare, registers). A design that wrapped on a power-of-two boundary or to address zero would issue a wrong address there. Fixed bursts start at unaligned addresses, which exposes a design that crosses the aligned window or runs past N words. Stops arrive during the latency wait and on the final word, and extra starts arrive in mid-burst. These cases catch a premature ready pulse, an extra word, and a busy start that restarts the sequence or raises an error. Refused starts cover all three reserved regions, both buffer spares in 32-word mode, and the undefined mode codes, while the accepted 32-word burst on boot spare is checked to pass.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int AW      = 16;  // word address width
  localparam int LEN_LOG = 5;   // log2 of the longest fixed burst
  localparam int NRGN    = 10;  // regions in the map

  localparam logic [2:0] MODE_CONT = 3'd0;
  localparam logic [2:0] MODE_W32  = 3'd4;
  localparam logic [2:0] MODE_MAX  = 3'd4;

  typedef enum logic [1:0] {RGN_PLAIN, RGN_BUFSPARE, RGN_RESV} rgn_kind_e;

  typedef struct packed {
    rgn_kind_e       kind;
    logic [AW-1:0]   base;
    logic [AW-1:0]   top;
  } rgn_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_BURST} st_e;

  localparam logic [AW-1:0] RGN_LO [NRGN] = '{
    16'h0000, 16'h0200, 16'h0600, 16'h0A00, 16'h8000,
    16'h8010, 16'h8030, 16'h8050, 16'h9000, 16'hF000};
  localparam logic [AW-1:0] RGN_HI [NRGN] = '{
    16'h01FF, 16'h05FF, 16'h09FF, 16'h7FFF, 16'h800F,
    16'h802F, 16'h804F, 16'h8FFF, 16'hEFFF, 16'hFFFF};
  localparam rgn_kind_e RGN_KIND [NRGN] = '{
    RGN_PLAIN, RGN_PLAIN, RGN_PLAIN, RGN_RESV, RGN_PLAIN,
    RGN_BUFSPARE, RGN_BUFSPARE, RGN_RESV, RGN_RESV, RGN_PLAIN};

endpackage

// File: rtl/burst_region_dec.sv
module burst_region_dec
  import burst_seq_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  output rgn_t          rgn_o
);

  // R3: the map is scanned entry by entry; the entries are disjoint and cover the space
  always_comb begin
    rgn_o = '{kind: RGN_RESV, base: '0, top: '0};
    for (int i = 0; i < NRGN; i++) begin
      if (addr_i >= RGN_LO[i] && addr_i <= RGN_HI[i]) begin
        rgn_o = '{kind: RGN_KIND[i], base: RGN_LO[i], top: RGN_HI[i]};
      end
    end
  end

endmodule

// File: rtl/burst_lat_cnt.sv
module burst_lat_cnt #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [LW-1:0] lat_i,
  input  logic          dec_i,
  output logic          done_o
);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= lat_i;
    end else if (dec_i) begin
      cnt_q <= cnt_q - LW'(1);
    end
  end

  // a loaded value of 0 or 1 both finish on the first wait edge
  assign done_o = (cnt_q <= LW'(1));

  // R2: the count only moves downward while waiting
  // R2
  lat_down_chk: assert property (@(posedge clk) disable iff (rst)
    dec_i && !load_i |=> cnt_q == $past(cnt_q) - LW'(1));

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_seq_pkg::*;
#(
  parameter int CW = LEN_LOG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] top_i,
  input  logic [2:0]    mode_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);

  logic [AW-1:0] addr_q, base_q, top_q, mask_q, nxt;
  logic [CW-1:0] remain_q;
  logic          fixed_q;
  logic [AW-1:0] len_mask;

  // N-1 for N = 4 << (mode-1), which is 2^(mode+1) - 1
  assign len_mask = (mode_i == MODE_CONT) ? '0
                  : ((AW'(1) << (mode_i + 3'd1)) - AW'(1));

  always_comb begin
    if (fixed_q) begin
      nxt = (addr_q & ~mask_q) | ((addr_q + AW'(1)) & mask_q);
    end else if (addr_q == top_q) begin
      nxt = base_q;
    end else begin
      nxt = addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      base_q   <= '0;
      top_q    <= '0;
      mask_q   <= '0;
      remain_q <= '0;
      fixed_q  <= 1'b0;
    end else if (load_i) begin
      addr_q   <= start_addr_i;
      base_q   <= base_i;
      top_q    <= top_i;
      mask_q   <= len_mask;
      remain_q <= CW'(len_mask);
      fixed_q  <= (mode_i != MODE_CONT);
    end else if (adv_i) begin
      addr_q   <= nxt;
      remain_q <= remain_q - CW'(1);
    end
  end

  assign addr_o = addr_q;
  assign last_o = fixed_q && (remain_q == '0);

  // R4
  cont_range_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i && !fixed_q |=> (addr_q >= base_q) && (addr_q <= top_q));

  // R5
  win_hold_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i && fixed_q |=> (addr_q & ~mask_q) == ($past(addr_q) & ~mask_q));

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [AW-1:0]    start_addr_i,
  input  logic [2:0]       mode_i,
  input  logic [LAT_W-1:0] latency_i,
  input  logic             ce_n_i,
  input  logic             rp_n_i,
  input  logic             rst_req_i,
  input  logic             we_n_i,
  output logic [AW-1:0]    addr_o,
  output logic             valid_o,
  output logic             ready_o,
  output logic             err_o
);

  st_e  st_q;
  rgn_t rgn;
  logic stop, accept_ok, try_start, load, bad, dec, adv, lat_done, last;

  assign stop = ce_n_i | ~rp_n_i | rst_req_i | ~we_n_i;

  burst_region_dec u_dec (
    .addr_i (start_addr_i),
    .rgn_o  (rgn)
  );

  assign accept_ok = (rgn.kind != RGN_RESV) && (mode_i <= MODE_MAX) &&
                     !(mode_i == MODE_W32 && rgn.kind == RGN_BUFSPARE);
  assign try_start = (st_q == ST_IDLE) && start_i && !stop;
  assign load      = try_start && accept_ok;
  assign bad       = try_start && !accept_ok;
  assign dec       = (st_q == ST_WAIT) && !stop && !lat_done;
  assign adv       = (st_q == ST_BURST) && !stop && !last;

  burst_lat_cnt #(.LW(LAT_W)) u_lat (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .lat_i  (latency_i),
    .dec_i  (dec),
    .done_o (lat_done)
  );

  burst_addr_step #(.CW(LEN_LOG)) u_step (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load),
    .adv_i        (adv),
    .start_addr_i (start_addr_i),
    .base_i       (rgn.base),
    .top_i        (rgn.top),
    .mode_i       (mode_i),
    .addr_o       (addr_o),
    .last_o       (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      valid_o <= 1'b0;
      ready_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      ready_o <= 1'b0;
      err_o   <= bad;
      case (st_q)
        ST_IDLE: begin
          valid_o <= 1'b0;
          if (load) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (stop) begin
            st_q <= ST_IDLE;
          end else if (lat_done) begin
            st_q    <= ST_BURST;
            valid_o <= 1'b1;
            ready_o <= 1'b1;
          end
        end
        ST_BURST: begin
          if (stop || last) begin
            st_q    <= ST_IDLE;
            valid_o <= 1'b0;
          end else begin
            valid_o <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> valid_o ##1 !ready_o);

  // R6
  stop_drop_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o && stop |=> !valid_o);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !valid_o && !ready_o);

  // R4
  addr_moves_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o || (addr_o != $past(addr_o)));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o && start_i |=> !err_o && !ready_o);

endmodule

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [15:0] saddr = '0;
  logic [2:0] smode = '0;
  logic [LAT_W-1:0] slat = '0;
  logic ce_n = 1'b0, rp_n = 1'b1, rst_req = 1'b0, we_n = 1'b1;
  logic [15:0] addr_o;
  logic valid_o, ready_o, err_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_seq #(.LAT_W(LAT_W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .start_addr_i(saddr),
    .mode_i(smode), .latency_i(slat), .ce_n_i(ce_n), .rp_n_i(rp_n),
    .rst_req_i(rst_req), .we_n_i(we_n), .addr_o(addr_o),
    .valid_o(valid_o), .ready_o(ready_o), .err_o(err_o));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // kind: 0 plain, 1 buffer spare, 2 reserved (R3)
  function automatic int rkind(input logic [15:0] a);
    if (a <= 16'h09FF) return 0;
    if (a <= 16'h7FFF) return 2;
    if (a <= 16'h800F) return 0;
    if (a <= 16'h804F) return 1;
    if (a <= 16'hEFFF) return 2;
    return 0;
  endfunction

  function automatic logic [15:0] rbase(input logic [15:0] a);
    if (a <= 16'h01FF) return 16'h0000;
    if (a <= 16'h05FF) return 16'h0200;
    if (a <= 16'h09FF) return 16'h0600;
    if (a <= 16'h800F) return 16'h8000;
    if (a <= 16'h802F) return 16'h8010;
    if (a <= 16'h804F) return 16'h8030;
    return 16'hF000;
  endfunction

  function automatic logic [15:0] rtop(input logic [15:0] a);
    if (a <= 16'h01FF) return 16'h01FF;
    if (a <= 16'h05FF) return 16'h05FF;
    if (a <= 16'h09FF) return 16'h09FF;
    if (a <= 16'h800F) return 16'h800F;
    if (a <= 16'h802F) return 16'h802F;
    if (a <= 16'h804F) return 16'h804F;
    return 16'hFFFF;
  endfunction

  function automatic bit legal(input logic [15:0] a, input logic [2:0] m);
    return (rkind(a) != 2) && (m <= 3'd4) && !(m == 3'd4 && rkind(a) == 1);
  endfunction

  function automatic logic [15:0] nxt(input logic [15:0] ea, input logic [2:0] m,
                                      input logic [15:0] a0);
    logic [15:0] msk;
    if (m == 3'd0) return (ea == rtop(a0)) ? rbase(a0) : ea + 16'd1;
    msk = (16'd4 << (m - 3'd1)) - 16'd1;
    return (ea & ~msk) | ((ea + 16'd1) & msk);
  endfunction

  function automatic int blen(input logic [2:0] m);
    return (m == 3'd0) ? 0 : (4 << (m - 3'd1));
  endfunction

  function automatic int end_k(input logic [2:0] m, input int lat, input int s);
    int l, e;
    l = (lat == 0) ? 1 : lat;
    e = (m == 3'd0) ? s : l + blen(m);
    if (s >= 1 && s < e) e = s;
    return e;
  endfunction

  task automatic idle_ctl();
    ce_n = 1'b0; rp_n = 1'b1; rst_req = 1'b0; we_n = 1'b1; start = 1'b0;
  endtask

  // s: edge index that sees a stop (-1 none); sk: stop kind 1..4; ik: edge of a busy start
  task automatic do_burst(input logic [15:0] a, input logic [2:0] m, input int lat,
                          input int s, input int sk, input int ik, input string tag);
    int l, ek;
    logic [15:0] ea;
    bit ev, er;
    @(negedge clk);
    start = 1'b1; saddr = a; smode = m; slat = LAT_W'(lat);
    @(negedge clk);
    start = 1'b0;
    if (!legal(a, m)) begin
      check(err_o && !valid_o && !ready_o, tag, "refused start flags",
            {29'd0, err_o, ready_o, valid_o}, 32'h4);
      @(negedge clk);
      check(!err_o && !valid_o, tag, "error flag one cycle",
            {29'd0, err_o, ready_o, valid_o}, 32'h0);
      return;
    end
    l  = (lat == 0) ? 1 : lat;
    ek = end_k(m, lat, s);
    ea = a;
    for (int k = 0; k <= ek; k++) begin
      if (k > 0) @(negedge clk);
      ev = (k >= l) && (k < ek);
      er = ev && (k == l);
      check({err_o, ready_o, valid_o} == {1'b0, er, ev} && (!ev || addr_o == ea),
            tag, $sformatf("edge %0d err/ready/valid/addr", k),
            {13'd0, err_o, ready_o, valid_o, addr_o},
            {13'd0, 1'b0, er, ev, ev ? ea : addr_o});
      if (ev) ea = nxt(ea, m, a);
      idle_ctl();
      if (sk != 0 && k + 1 == s) begin
        case (sk)
          1: ce_n = 1'b1;
          2: rp_n = 1'b0;
          3: rst_req = 1'b1;
          default: we_n = 1'b0;
        endcase
      end
      if (ik > 0 && k + 1 == ik) begin
        start = 1'b1; saddr = 16'h0A00; smode = 3'd0;
      end
    end
    @(negedge clk);
    check(!valid_o && !err_o, tag, "idle after burst", {30'd0, err_o, valid_o}, 32'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!valid_o && !ready_o && !err_o, "R1", "outputs in reset",
          {29'd0, err_o, ready_o, valid_o}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(!valid_o && !ready_o && !err_o, "R1", "outputs after reset",
          {29'd0, err_o, ready_o, valid_o}, 32'h0);

    // R2: latencies, including 0 acting as 1
    do_burst(16'h0010, 3'd1, 0, -1, 0, 0, "R2");
    do_burst(16'h0010, 3'd1, 1, -1, 0, 0, "R2");
    do_burst(16'h0123, 3'd2, 7, -1, 0, 0, "R2");
    // R3 / R4: continuous wrap at uneven region tops
    do_burst(16'h05FC, 3'd0, 2, 12, 1, 0, "R4");
    do_burst(16'hFFFE, 3'd0, 1, 6, 2, 0, "R3");
    do_burst(16'h800E, 3'd0, 3, 25, 3, 0, "R3");
    do_burst(16'h804D, 3'd0, 1, 40, 4, 0, "R4");
    // R5: unaligned fixed windows
    do_burst(16'h0205, 3'd2, 2, -1, 0, 0, "R5");
    do_burst(16'h061E, 3'd3, 1, -1, 0, 0, "R5");
    do_burst(16'hF00B, 3'd4, 2, -1, 0, 0, "R5");
    // R8: 32-word on boot spare accepted, on buffer spares refused, bad codes refused
    do_burst(16'h8007, 3'd4, 1, -1, 0, 0, "R8");
    do_burst(16'h8010, 3'd4, 1, -1, 0, 0, "R8");
    do_burst(16'h804F, 3'd4, 1, -1, 0, 0, "R8");
    do_burst(16'h0000, 3'd5, 1, -1, 0, 0, "R8");
    do_burst(16'h0000, 3'd7, 1, -1, 0, 0, "R8");
    // R7: each reserved region
    do_burst(16'h0A00, 3'd1, 1, -1, 0, 0, "R7");
    do_burst(16'h8FFF, 3'd0, 1, -1, 0, 0, "R7");
    do_burst(16'h9000, 3'd2, 1, -1, 0, 0, "R7");
    // R6: stop in wait, stop on the last word
    do_burst(16'h0300, 3'd1, 5, 3, 1, 0, "R6");
    do_burst(16'h0300, 3'd1, 2, 5, 4, 0, "R6");
    do_burst(16'h0300, 3'd2, 1, 8, 3, 0, "R6");
    // R9: busy starts and start with a stop present
    do_burst(16'h0700, 3'd0, 2, 20, 1, 6, "R9");
    do_burst(16'h0040, 3'd3, 3, -1, 0, 2, "R9");
    @(negedge clk);
    ce_n = 1'b1; start = 1'b1; saddr = 16'h0000; smode = 3'd1; slat = LAT_W'(1);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(!valid_o && !err_o && !ready_o, "R9", "start under stop ignored",
            {29'd0, err_o, ready_o, valid_o}, 32'h0);
      @(negedge clk);
    end
    idle_ctl();
    do_burst(16'h0100, 3'd1, 1, -1, 0, 0, "R9");

    // random mix
    for (int i = 0; i < 80; i++) begin
      logic [15:0] lo [10] = '{16'h0000, 16'h0200, 16'h0600, 16'h0A00, 16'h8000,
                               16'h8010, 16'h8030, 16'h8050, 16'h9000, 16'hF000};
      logic [15:0] hi [10] = '{16'h01FF, 16'h05FF, 16'h09FF, 16'h7FFF, 16'h800F,
                               16'h802F, 16'h804F, 16'h8FFF, 16'hEFFF, 16'hFFFF};
      int r, lat, s, sk, ik, ek, l;
      logic [15:0] a;
      logic [2:0] m;
      r   = $urandom % 10;
      a   = lo[r] + 16'($urandom % (int'(hi[r]) - int'(lo[r]) + 1));
      m   = 3'($urandom % 8);
      lat = $urandom % 6;
      l   = (lat == 0) ? 1 : lat;
      if (m == 3'd0) s = l + 1 + ($urandom % 40);
      else if ($urandom % 2) s = -1;
      else s = 1 + ($urandom % (l + blen(m)));
      sk = 1 + ($urandom % 4);
      ek = end_k(m, lat, s);
      ik = (ek > 1 && ($urandom % 3) == 0) ? 1 + ($urandom % (ek - 1)) : 0;
      do_burst(a, m, lat, s, sk, ik, (m == 3'd0) ? "R4" : "R5");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule